// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block sits in the bit-clock domain at the front of a stereo audio path. It takes a bit clock, a word-select line and a serial data line. From them it recovers the left and right samples and delivers each one as a parallel word with a one-cycle valid strobe. The two channels share the data line. Word select tells them apart: low means left and high means right.

A 3-bit format code picks the framing. The choices are a delayed-MSB framing (MSB one bit clock after the word-select change), an MSB-first framing (MSB in the first bit after the change), and three LSB-last framings of 16, 18 or 20 bits. In the LSB-last framings the sample is the last N bits before the next word-select change. Every result is left-aligned in a 20-bit word, with unused low bits set to zero. The source drives word select on the falling edge of the bit clock. The block samples data and word select on the rising edge.

The slot that ends at the first word-select change after reset may be partial, so it is never delivered. Clock-domain crossing and any filtering downstream are outside this block.

Top module: `serial_audio_rx`

## Requirements
- R1: With format code 000, the MSB is the bit sampled one bit clock after the word-select change. The following bits fill the word toward its LSB.
- R2: With format code 100, the MSB is the first bit sampled after the word-select change. The following bits fill the word toward its LSB.
- R3: With format codes 001, 010 and 011, the sample is the last 16, 18 or 20 bits (respectively) before the next word-select change. The last of those bits is the LSB.
- R4: Output words are 20 bits wide with the MSB at bit 19. In the formats of R1 and R2, bits past the 20th are ignored and missing low bits read as zero. In the formats of R3, the low 4, 2 or 0 bits read as zero.
- R5: A slot sent with word select low is delivered on the left outputs. A slot sent with word select high is delivered on the right outputs. The two strobes are never high together.
- R6: A slot's strobe is high for exactly one bit-clock cycle. It is registered by the rising edge that samples the first bit of the following slot. For code 000 that is one cycle after the word-select change; for the other codes it is the cycle of the change.
- R7: Reset clears both words and both strobes. Each word holds its value between its own strobes.
- R8: No strobe is produced for the slot that ends at the first word-select change seen after reset.
- R9: Codes 101, 110 and 111 force both words to zero and keep both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; data and word select are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ws | input | 1 | Word select, 0 = left slot, 1 = right slot |
| sd | input | 1 | Serial data, MSB first |
| fmt | input | 3 | Framing code (see R1 to R3, R9) |
| left_word | output | 20 | Last delivered left sample, left-aligned |
| left_vld | output | 1 | One-cycle strobe for a new left sample |
| right_word | output | 20 | Last delivered right sample, left-aligned |
| right_vld | output | 1 | One-cycle strobe for a new right sample |

## Verification
A slot's result is due in the register stage fed by the rising edge that samples the first bit of the next slot. For the MSB-first and LSB-last codes that is the edge of the word-select change; for the delayed-MSB code it is one edge later. The bench computes, for every bit-clock cycle of a stream, whether a strobe is due and on which channel. It then compares both strobes and both words at the following falling edge, so each result is checked in exactly the cycle it is due. Between strobes it checks that each word equals the last value expected for that channel.

// File: rtl/audrx_pkg.sv
package audrx_pkg;

    localparam int WORD_W = 20;

    localparam logic [2:0] FMT_DLY_MSB = 3'd0;
    localparam logic [2:0] FMT_LSB16   = 3'd1;
    localparam logic [2:0] FMT_LSB18   = 3'd2;
    localparam logic [2:0] FMT_LSB20   = 3'd3;
    localparam logic [2:0] FMT_MSB     = 3'd4;

    localparam int CH_LEFT  = 0;
    localparam int CH_RIGHT = 1;

    // slot boundary event seen at one rising edge of the bit clock
    typedef struct packed {
        logic start;    // first bit of a new effective slot sampled now
        logic deliver;  // previous slot is complete and may be emitted
        logic chan;     // channel of the slot that just ended (1 = right)
    } slot_evt_t;

    function automatic logic fmt_known(input logic [2:0] code);
        return code <= FMT_MSB;
    endfunction

    function automatic logic fmt_delayed(input logic [2:0] code);
        return code == FMT_DLY_MSB;
    endfunction

endpackage

// File: rtl/audrx_slot_track.sv
module audrx_slot_track
    import audrx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ws,
    input  logic      delayed,
    input  logic      fmt_ok,
    output slot_evt_t evt
);

    logic ws_d1;
    logic ws_d2;
    logic seen_edge;
    logic eff_now;
    logic eff_old;

    // the delayed-MSB framing is the MSB-first framing on a word select
    // that lags by one bit clock
    always_comb begin
        eff_now     = delayed ? ws_d1 : ws;
        eff_old     = delayed ? ws_d2 : ws_d1;
        evt.start   = eff_now ^ eff_old;
        evt.deliver = evt.start & seen_edge;
        evt.chan    = eff_old;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ws_d1     <= 1'b0;
            ws_d2     <= 1'b0;
            seen_edge <= 1'b0;
        end else begin
            ws_d1     <= ws;
            ws_d2     <= ws_d1;
            if (!fmt_ok)
                seen_edge <= 1'b0;
            else if (evt.start)
                seen_edge <= 1'b1;
        end
    end

endmodule

// File: rtl/audrx_bit_collector.sv
module audrx_bit_collector
    import audrx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sd,
    input  logic         start,
    input  logic [2:0]   fmt,
    output logic [W-1:0] word_done
);

    localparam int           CW  = $clog2(W + 1);
    localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

    logic [W-1:0]  acc;   // MSB-first accumulation of the running slot
    logic [W-1:0]  hist;  // last W bits seen, newest at bit 0
    logic [CW-1:0] cnt;
    logic [W-1:0]  sel;

    assign sel = TOP >> cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            hist <= '0;
            cnt  <= '0;
        end else begin
            hist <= {hist[W-2:0], sd};
            if (start) begin
                acc <= sd ? TOP : '0;
                cnt <= CW'(1);
            end else if (cnt < CW'(W)) begin
                acc <= sd ? (acc | sel) : (acc & ~sel);
                cnt <= cnt + 1'b1;
            end
        end
    end

    // value of the slot that ends at the current start event
    always_comb begin
        unique case (fmt)
            FMT_LSB16: word_done = W'(hist[15:0]) << (W - 16);
            FMT_LSB18: word_done = W'(hist[17:0]) << (W - 18);
            FMT_LSB20: word_done = W'(hist[19:0]) << (W - 20);
            default:   word_done = acc;
        endcase
    end

endmodule

// File: rtl/audrx_chan_regs.sv
module audrx_chan_regs
    import audrx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         fmt_ok,
    input  slot_evt_t    evt,
    input  logic [W-1:0] word_in,
    output logic [W-1:0] left_word,
    output logic         left_vld,
    output logic [W-1:0] right_word,
    output logic         right_vld
);

    localparam int NCH = 2;

    logic [NCH-1:0][W-1:0] word_q;
    logic [NCH-1:0]        vld_q;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic hit;
        assign hit = evt.deliver && (evt.chan == 1'(c));

        always_ff @(posedge clk) begin
            if (rst || !fmt_ok) begin
                word_q[c] <= '0;
                vld_q[c]  <= 1'b0;
            end else begin
                vld_q[c] <= hit;
                if (hit)
                    word_q[c] <= word_in;
            end
        end
    end

    assign left_word  = word_q[CH_LEFT];
    assign left_vld   = vld_q[CH_LEFT];
    assign right_word = word_q[CH_RIGHT];
    assign right_vld  = vld_q[CH_RIGHT];

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import audrx_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  logic         bclk,
    input  logic         rst,
    input  logic         ws,
    input  logic         sd,
    input  logic [2:0]   fmt,
    output logic [W-1:0] left_word,
    output logic         left_vld,
    output logic [W-1:0] right_word,
    output logic         right_vld
);

    slot_evt_t    evt;
    logic         fmt_ok;
    logic [W-1:0] word_done;

    assign fmt_ok = fmt_known(fmt);

    audrx_slot_track u_track (
        .clk     (bclk),
        .rst     (rst),
        .ws      (ws),
        .delayed (fmt_delayed(fmt)),
        .fmt_ok  (fmt_ok),
        .evt     (evt)
    );

    audrx_bit_collector #(.W(W)) u_collect (
        .clk       (bclk),
        .rst       (rst),
        .sd        (sd),
        .start     (evt.start),
        .fmt       (fmt),
        .word_done (word_done)
    );

    audrx_chan_regs #(.W(W)) u_out (
        .clk        (bclk),
        .rst        (rst),
        .fmt_ok     (fmt_ok),
        .evt        (evt),
        .word_in    (word_done),
        .left_word  (left_word),
        .left_vld   (left_vld),
        .right_word (right_word),
        .right_vld  (right_vld)
    );

endmodule

// File: rtl/audrx_chk.sv
module audrx_chk #(
    parameter int W = 20
) (
    input logic         bclk,
    input logic         rst,
    input logic [2:0]   fmt,
    input logic [W-1:0] left_word,
    input logic         left_vld,
    input logic [W-1:0] right_word,
    input logic         right_vld
);

    p_one_chan_r5: assert property (@(posedge bclk) disable iff (rst)
        !(left_vld && right_vld));

    p_left_pulse_r6: assert property (@(posedge bclk) disable iff (rst)
        left_vld |=> !left_vld);

    p_right_pulse_r6: assert property (@(posedge bclk) disable iff (rst)
        right_vld |=> !right_vld);

    p_left_hold_r7: assert property (@(posedge bclk) disable iff (rst)
        (!left_vld && !$past(rst) && $past(fmt) <= 3'd4) |-> $stable(left_word));

    p_right_hold_r7: assert property (@(posedge bclk) disable iff (rst)
        (!right_vld && !$past(rst) && $past(fmt) <= 3'd4) |-> $stable(right_word));

    p_after_reset_r8: assert property (@(posedge bclk) disable iff (rst)
        $past(rst) |-> (!left_vld && !right_vld));

    p_lsb16_zero_r4: assert property (@(posedge bclk) disable iff (rst)
        (left_vld && $past(fmt) == 3'd1) |-> (left_word[3:0] == 4'd0));

    p_unused_r9: assert property (@(posedge bclk) disable iff (rst)
        (!$past(rst) && $past(fmt) > 3'd4) |->
            (!left_vld && !right_vld && left_word == '0 && right_word == '0));

endmodule

bind serial_audio_rx audrx_chk #(.W(W)) u_chk (
    .bclk       (bclk),
    .rst        (rst),
    .fmt        (fmt),
    .left_word  (left_word),
    .left_vld   (left_vld),
    .right_word (right_word),
    .right_vld  (right_vld)
);

// File: tb/serial_audio_rx_tb.sv
`timescale 1ns/1ps
module serial_audio_rx_tb;

    localparam int W  = 20;
    localparam int NH = 8;

    logic         bclk = 1'b0;
    logic         rst  = 1'b1;
    logic         ws   = 1'b0;
    logic         sd   = 1'b0;
    logic [2:0]   fmt  = 3'd0;
    logic [W-1:0] left_word, right_word;
    logic         left_vld, right_vld;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [W-1:0] exp_w [NH];
    int cur_f, cur_h, cur_p, cur_off;
    logic [W-1:0] last_l, last_r;

    serial_audio_rx u_dut (
        .bclk(bclk), .rst(rst), .ws(ws), .sd(sd), .fmt(fmt),
        .left_word(left_word), .left_vld(left_vld),
        .right_word(right_word), .right_vld(right_vld)
    );

    always #2.5 bclk = ~bclk;

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit known(input int f);
        return f <= 4;
    endfunction

    function automatic int lsb_n(input int f);
        case (f)
            1: return 16;
            2: return 18;
            3: return 20;
            default: return 0;
        endcase
    endfunction

    function automatic logic junk();
        return 1'($urandom % 2);
    endfunction

    task automatic make_words();
        int keep;
        keep = (lsb_n(cur_f) > 0) ? lsb_n(cur_f) : ((cur_h < W) ? cur_h : W);
        for (int k = 0; k < NH; k++) begin
            logic [31:0] r;
            r = $urandom & 32'hFFFFF;
            if (keep < W) r = r & ~((32'd1 << (W - keep)) - 1);
            exp_w[k] = r[W-1:0];
        end
    endtask

    function automatic logic ws_for(input int i);
        int s;
        s = i - cur_p;
        if (s < 0) return 1'b0;
        return ((s / cur_h) % 2) == 0;
    endfunction

    function automatic logic bit_for(input int i);
        int e, eh, p, n;
        e = i - cur_p - cur_off;
        if (e < 0) return junk();
        eh = e / cur_h;
        p  = e % cur_h;
        if (eh >= NH) return junk();
        n = lsb_n(cur_f);
        if (n > 0) begin
            if (p >= cur_h - n) return exp_w[eh][W-1-(p-(cur_h-n))];
            return junk();
        end
        if (p < W) return exp_w[eh][W-1-p];
        return junk();
    endfunction

    task automatic drive(input int i);
        ws = ws_for(i);
        sd = bit_for(i);
    endtask

    task automatic run(input int f, input int h, input int p);
        int total;
        string wtag;
        cur_f = f; cur_h = h; cur_p = p;
        cur_off = (f == 0) ? 1 : 0;
        make_words();
        fmt = 3'(f);
        rst = 1'b1; ws = 1'b0; sd = 1'b0;
        repeat (3) @(negedge bclk);
        // R7: reset state
        chk(left_word == '0 && right_word == '0 && !left_vld && !right_vld,
            "R7 reset state", {left_vld, right_vld, left_word[9:0], right_word[9:0]}, 0);
        rst = 1'b0;
        last_l = '0; last_r = '0;
        if (f == 0) wtag = "R1";
        else if (f == 4) wtag = "R2";
        else wtag = "R3";
        if ((f == 0 || f == 4) && h != W) wtag = {wtag, " R4"};
        else if (f == 1 || f == 2) wtag = {wtag, " R4"};
        drive(0);
        total = p + cur_off + (NH - 1) * h + 2;
        for (int i = 0; i < total; i++) begin
            int e, hh;
            bit emit, rt;
            string vtag;
            @(negedge bclk);
            e = i - p - cur_off;
            emit = 0; rt = 0; hh = 0;
            if (known(f) && e > 0 && (e % h) == 0) begin
                hh = e / h;
                if (hh >= 1 && hh <= NH - 1) begin
                    emit = 1;
                    rt = ((hh - 1) % 2) == 0;
                end
            end
            if (!known(f)) vtag = "R9 strobe";
            else if (e < h) vtag = "R8 strobe";
            else vtag = "R5/R6 strobe";
            chk(left_vld == (emit && !rt), vtag, left_vld, (emit && !rt));
            chk(right_vld == (emit && rt), vtag, right_vld, (emit && rt));
            if (emit && rt) begin
                chk(right_word == exp_w[hh-1], {wtag, " right word"}, right_word, exp_w[hh-1]);
                last_r = exp_w[hh-1];
            end else begin
                chk(right_word == last_r, known(f) ? "R7 right hold" : "R9 right zero",
                    right_word, last_r);
            end
            if (emit && !rt) begin
                chk(left_word == exp_w[hh-1], {wtag, " left word"}, left_word, exp_w[hh-1]);
                last_l = exp_w[hh-1];
            end else begin
                chk(left_word == last_l, known(f) ? "R7 left hold" : "R9 left zero",
                    left_word, last_l);
            end
            drive(i + 1);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // directed corners
        run(4, 32, 3);   // R2, bits past 20 ignored (R4)
        run(4, 16, 0);   // R2, zero fill (R4)
        run(0, 32, 5);   // R1
        run(0, 16, 2);   // R1 short slot (R4)
        run(0, 20, 0);   // R1 exact fit
        run(1, 32, 1);   // R3 16 bits
        run(2, 24, 4);   // R3 18 bits
        run(3, 20, 0);   // R3 20 bits, slot exactly full
        run(1, 16, 6);   // R3 16 bits, slot exactly full
        run(5, 32, 0);   // R9
        run(7, 24, 2);   // R9
        // constrained random
        for (int k = 0; k < 10; k++)
            run(int'($urandom % 5), 20 + int'($urandom % 13), int'($urandom % 8));
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule